// File: doc/BRIEF.md
# UART Automatic RTS/CTS Handshake Controller

This block adds automatic hardware handshaking to a UART with a 64-entry receive FIFO. On the transmit side, it watches the CTS line and tells the transmitter whether it may start another character. A request to stop never cuts a character short. If a character is being shifted out when CTS rises, permission is withdrawn only after that character's stop bit has left the shifter.

On the receive side, the block compares the FIFO fill count with a pair of thresholds tied to the selected trigger level. RTS turns off (high) when the FIFO climbs to the upper threshold. It turns back on (low) only when the FIFO has drained to the lower threshold. Between the two thresholds it keeps its previous state. The same trigger level drives a level-sensitive receive-data interrupt request. The FIFO keeps accepting data while RTS is off, until it is completely full. No data passes through the block itself, so every pin is a plain control or status pin and there is no valid/ready back-pressure at its edge.

Top module: `uaf_flow_ctrl`

## Requirements
- R1: While reset is asserted, `rts_out` is 1, `rx_irq` is 0, and `tx_allow` is 0 whenever `auto_cts_en` is 1.
- R2: With auto-CTS on, if the synchronized CTS is 1 while `tx_busy` is 1, `tx_allow` stays 1. It drops on the clock edge after the cycle in which `char_done` is 1.
- R3: With auto-CTS on and the transmitter idle (`tx_busy` 0), `tx_allow` becomes 0 on the third rising edge after `cts_in` rises: two synchronizer stages plus one register.
- R4: With auto-CTS on, `tx_allow` returns to 1 on the third rising edge after `cts_in` falls to 0.
- R5: `trig_sel` selects the trigger level as 00=1, 01=16, 10=32 and 11=56. `rx_irq` is 1 on the edge after any cycle in which `rx_count` is at least the selected level, and 0 otherwise.
- R6: With auto-RTS on, `rts_out` is 1 on the edge after any cycle in which `rx_count` is at least the negate level. The negate levels are 16, 32, 56 and 60 for `trig_sel` 00, 01, 10 and 11.
- R7: With auto-RTS on, `rts_out` is 0 on the edge after any cycle in which `rx_count` is at most the re-assert level. The re-assert levels are 1, 8, 16 and 32 for `trig_sel` 00, 01, 10 and 11. Strictly between the two levels, `rts_out` holds its value.
- R8: With auto-RTS off, `rts_out` equals `sw_rts` as sampled on the previous rising edge.
- R9: With auto-CTS off, `tx_allow` is 1 in the same cycle, whatever CTS does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_rts_en | input | 1 | 1 enables automatic RTS control |
| auto_cts_en | input | 1 | 1 enables automatic CTS gating |
| trig_sel | input | 2 | Receive trigger level select (00=1, 01=16, 10=32, 11=56) |
| rx_count | input | 7 | Receive FIFO fill count, 0 to 64 |
| sw_rts | input | 1 | Software RTS level, used when auto-RTS is off |
| cts_in | input | 1 | Asynchronous CTS line, 1 = remote asks to stop |
| tx_busy | input | 1 | Transmitter is shifting a character |
| char_done | input | 1 | One-cycle pulse when the stop bit has been shifted out |
| rts_out | output | 1 | RTS line, 1 = off (local FIFO asks to stop) |
| tx_allow | output | 1 | 1 = transmitter may start a new character |
| rx_irq | output | 1 | Receive-data interrupt request (level) |

## Verification
The fill count is swept up from empty to full and back down under every trigger selection. This exposes a wrong negate or re-assert level, missing hysteresis, or a swapped select encoding. A random walk of the count, mixed with jumps across both thresholds, tells a held RTS state apart from one that merely follows the current count.

CTS rises are placed both while the transmitter is idle and in the middle of long characters. These separate an immediate stop from a stop that waits for `char_done`, and they also check the synchronizer delay. The enable bits and `sw_rts` are toggled at random to confirm the bypass paths.

// File: rtl/uaf_pkg.sv
package uaf_pkg;

  typedef logic [1:0] trig_sel_t;

  // Trigger level: 1, D/4, D/2, D-8 (1, 16, 32, 56 for D=64)
  function automatic int lvl_trigger(input int depth, input trig_sel_t sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 8;
    endcase
  endfunction

  // Level at which RTS is turned off
  function automatic int lvl_negate(input int depth, input trig_sel_t sel);
    case (sel)
      2'd0:    return depth / 4;
      2'd1:    return depth / 2;
      2'd2:    return depth - 8;
      default: return depth - 4;
    endcase
  endfunction

  // Level at or below which RTS is turned on again
  function automatic int lvl_reassert(input int depth, input trig_sel_t sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 8;
      2'd2:    return depth / 4;
      default: return depth / 2;
    endcase
  endfunction

endpackage

// File: rtl/uaf_cts_sync.sv
module uaf_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/uaf_tx_gate.sv
module uaf_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_stop,
  input  logic tx_busy,
  input  logic char_done,
  input  logic auto_cts_en,
  output logic tx_allow
);
  logic allow_q;
  logic boundary;

  // A stop may take effect only between characters
  assign boundary = !tx_busy || char_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    allow_q <= 1'b0;
    else if (!cts_stop)            allow_q <= 1'b1;
    else if (boundary)             allow_q <= 1'b0;
  end

  assign tx_allow = !auto_cts_en || allow_q;
endmodule

// File: rtl/uaf_rx_level.sv
module uaf_rx_level
  import uaf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  trig_sel_t        trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  output logic             off_next,
  output logic             rx_irq
);
  int   cnt_i;
  logic off_q;
  logic at_neg, at_re, at_trig;

  assign cnt_i   = int'(rx_count);
  assign at_neg  = cnt_i >= lvl_negate(DEPTH, trig_sel);
  assign at_re   = cnt_i <= lvl_reassert(DEPTH, trig_sel);
  assign at_trig = cnt_i >= lvl_trigger(DEPTH, trig_sel);

  always_comb begin
    off_next = off_q;
    if (at_neg)     off_next = 1'b1;
    else if (at_re) off_next = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= 1'b1;
      rx_irq <= 1'b0;
    end else begin
      off_q  <= off_next;
      rx_irq <= at_trig;
    end
  end
endmodule

// File: rtl/uaf_flow_ctrl.sv
module uaf_flow_ctrl
  import uaf_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int SYNC_STG  = 2,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             sw_rts,
  input  logic             cts_in,
  input  logic             tx_busy,
  input  logic             char_done,
  output logic             rts_out,
  output logic             tx_allow,
  output logic             rx_irq
);
  logic cts_stop;
  logic off_next;

  uaf_cts_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(cts_in), .d_sync(cts_stop)
  );

  uaf_tx_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cts_stop(cts_stop), .tx_busy(tx_busy),
    .char_done(char_done), .auto_cts_en(auto_cts_en), .tx_allow(tx_allow)
  );

  uaf_rx_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
    .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .rx_count(rx_count),
    .off_next(off_next), .rx_irq(rx_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_out <= 1'b1;
    else        rts_out <= auto_rts_en ? off_next : sw_rts;
  end
endmodule

// File: rtl/uaf_flow_ctrl_chk.sv
module uaf_flow_ctrl_chk
  import uaf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             auto_rts_en,
  input logic             auto_cts_en,
  input logic [1:0]       trig_sel,
  input logic [CNT_W-1:0] rx_count,
  input logic             sw_rts,
  input logic             tx_busy,
  input logic             char_done,
  input logic             rts_out,
  input logic             tx_allow,
  input logic             rx_irq
);
  p_irq_at_trigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_count) >= lvl_trigger(DEPTH, trig_sel)) |=> rx_irq);

  p_irq_below_trigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_count) < lvl_trigger(DEPTH, trig_sel)) |=> !rx_irq);

  p_rts_off_at_negate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && int'(rx_count) >= lvl_negate(DEPTH, trig_sel)) |=> rts_out);

  p_rts_on_at_reassert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && int'(rx_count) <= lvl_reassert(DEPTH, trig_sel)) |=> !rts_out);

  p_rts_software_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> (rts_out == $past(sw_rts)));

  p_no_midchar_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && tx_busy && !char_done && tx_allow) |=> (tx_allow || !auto_cts_en));

  p_cts_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en |-> tx_allow);
endmodule

bind uaf_flow_ctrl uaf_flow_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
  .trig_sel(trig_sel), .rx_count(rx_count), .sw_rts(sw_rts), .tx_busy(tx_busy),
  .char_done(char_done), .rts_out(rts_out), .tx_allow(tx_allow), .rx_irq(rx_irq)
);

// File: tb/uaf_flow_ctrl_tb_top.sv
module uaf_flow_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_rts_en = 1'b1, auto_cts_en = 1'b1;
  logic [1:0] trig_sel = 2'd0;
  logic [CNT_W-1:0] rx_count = '0;
  logic sw_rts = 1'b0, cts_in = 1'b0, tx_busy = 1'b0, char_done = 1'b0;
  logic rts_out, tx_allow, rx_irq;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uaf_flow_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .trig_sel(trig_sel), .rx_count(rx_count), .sw_rts(sw_rts), .cts_in(cts_in),
    .tx_busy(tx_busy), .char_done(char_done), .rts_out(rts_out),
    .tx_allow(tx_allow), .rx_irq(rx_irq)
  );

  // Expected levels from the requirement tables
  function automatic int f_trig(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 16; 2'd2: return 32; default: return 56; endcase
  endfunction
  function automatic int f_neg(input logic [1:0] s);
    case (s) 2'd0: return 16; 2'd1: return 32; 2'd2: return 56; default: return 60; endcase
  endfunction
  function automatic int f_re(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 8; 2'd2: return 16; default: return 32; endcase
  endfunction

  // Behavioural expectation, advanced on each rising edge from the inputs
  logic m_s1 = 1'b1, m_s2 = 1'b1, m_allow = 1'b0, m_off = 1'b1, m_irq = 1'b0, m_rts = 1'b1;
  string tag_rts = "R1", tag_tx = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1'b1; m_s2 = 1'b1; m_allow = 1'b0; m_off = 1'b1; m_irq = 1'b0; m_rts = 1'b1;
      tag_rts = "R1"; tag_tx = "R1";
    end else begin
      if (!m_s2) begin m_allow = 1'b1; tag_tx = "R4"; end
      else if (!tx_busy || char_done) begin
        m_allow = 1'b0; tag_tx = tx_busy ? "R2" : "R3";
      end else tag_tx = "R2";
      m_s2 = m_s1; m_s1 = cts_in;
      if (int'(rx_count) >= f_neg(trig_sel)) begin m_off = 1'b1; tag_rts = "R6"; end
      else if (int'(rx_count) <= f_re(trig_sel)) begin m_off = 1'b0; tag_rts = "R7"; end
      else tag_rts = "R7";
      m_irq = int'(rx_count) >= f_trig(trig_sel);
      if (auto_rts_en) m_rts = m_off;
      else begin m_rts = sw_rts; tag_rts = "R8"; end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R5", rx_irq, m_irq, "rx_irq");
    check(tag_rts, rts_out, m_rts, "rts_out");
    if (!auto_cts_en) check("R9", tx_allow, 1'b1, "tx_allow bypass");
    else check(tag_tx, tx_allow, m_allow, "tx_allow");
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic sweep(input logic [1:0] s);
    trig_sel = s;
    for (int c = 0; c <= DEPTH; c++) begin rx_count = CNT_W'(c); step(); end
    for (int c = DEPTH; c >= 0; c--) begin rx_count = CNT_W'(c); step(); end
  endtask

  // Character of given length, with char_done on its last busy cycle
  task automatic send_char(input int len);
    tx_busy = 1'b1;
    for (int i = 0; i < len; i++) begin
      char_done = (i == len - 1);
      step();
    end
    tx_busy = 1'b0; char_done = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0C75));
    // R1: reset values
    repeat (3) @(negedge clk);
    check("R1", rts_out, 1'b1, "rts_out in reset");
    check("R1", rx_irq, 1'b0, "rx_irq in reset");
    check("R1", tx_allow, 1'b0, "tx_allow in reset");
    rst_n = 1'b1;
    repeat (4) step();

    // R5 R6 R7: fill and drain under each trigger selection
    for (int s = 0; s < 4; s++) sweep(2'(s));

    // R3 R4: CTS while idle
    cts_in = 1'b1; repeat (2) step();
    check("R3", tx_allow, 1'b1, "tx_allow two edges after CTS rise");
    step();
    check("R3", tx_allow, 1'b0, "tx_allow three edges after CTS rise");
    cts_in = 1'b0; repeat (3) step();
    check("R4", tx_allow, 1'b1, "tx_allow after CTS fall");

    // R2: CTS rise in the middle of a long character
    fork
      send_char(20);
      begin repeat (3) @(negedge clk); cts_in = 1'b1; end
    join
    step();
    check("R2", tx_allow, 1'b0, "tx_allow after stop bit");
    cts_in = 1'b0; repeat (4) step();

    // R9: auto-CTS off ignores CTS
    auto_cts_en = 1'b0; cts_in = 1'b1;
    repeat (5) step();
    check("R9", tx_allow, 1'b1, "tx_allow with auto-CTS off");
    auto_cts_en = 1'b1; cts_in = 1'b0; repeat (4) step();

    // R8: software RTS
    auto_rts_en = 1'b0;
    for (int i = 0; i < 8; i++) begin sw_rts = i[0]; step(); end

    // Random mix
    auto_rts_en = 1'b1;
    begin
      int cnt = 0, busy_left = 0;
      for (int n = 0; n < 6000; n++) begin
        int r = $urandom_range(0, 99);
        if (r < 3) cnt = $urandom_range(0, DEPTH);
        else cnt = cnt + $urandom_range(0, 6) - 3;
        if (cnt < 0) cnt = 0;
        if (cnt > DEPTH) cnt = DEPTH;
        rx_count = CNT_W'(cnt);
        if ($urandom_range(0, 199) == 0) trig_sel = 2'($urandom_range(0, 3));
        if ($urandom_range(0, 29) == 0) cts_in = ~cts_in;
        if ($urandom_range(0, 299) == 0) auto_cts_en = ~auto_cts_en;
        if ($urandom_range(0, 299) == 0) auto_rts_en = ~auto_rts_en;
        sw_rts = 1'($urandom_range(0, 1));
        if (busy_left == 0 && tx_allow && $urandom_range(0, 3) == 0)
          busy_left = $urandom_range(3, 15);
        tx_busy = busy_left > 0;
        char_done = busy_left == 1;
        if (busy_left > 0) busy_left--;
        step();
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule